// File: doc/BRIEF.md
# Programmable Divider and Timer

This block keeps two time bases for a small processor subsystem. A free-running divider advances by one every 256 system clocks and can be cleared by software. Next to it, a programmable 8-bit counter advances at one of four selectable rates when enabled. When the counter wraps past its top value it reloads from a modulo register and sends a one-cycle interrupt request to the interrupt controller.

Software reaches the four registers through a byte-wide register port with a write strobe and a combinational read path. A divider clear is held back until the processor marks the last clock of the instruction that wrote it, using `op_end`. That way the divider never shows counts gathered during that instruction after the clear. The register port carries no data stream, so it has no valid/ready handshake. Writes are accepted in the cycle the strobe is high and never stall.

Top module: `tmr_top`

## Requirements
- R1: After reset the divider, counter and modulo read 0x00 and the control register reads 0xF8. Control bits 7 to 3 always read as 1.
- R2: The divider (offset 4) reads the number of elapsed clocks divided by 256, counted from reset or from the last clear.
- R3: A write of any value to offset 4 marks a clear. The divider keeps counting until a cycle with `op_end` high. After that cycle it reads 0, and counting starts again from zero. A write with `op_end` high in the same cycle clears at once.
- R4: With control bit 2 at 0 the counter and its prescaler hold their values. Setting the bit resumes counting from the held prescaler position.
- R5: Control bits 1:0 pick the counter period in clocks: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256. The first increment arrives that many clocks after the enable takes effect.
- R6: When the counter steps from 0xFF, it loads the modulo value and `irq_o` is high for exactly one cycle, the same cycle in which the reloaded value is first visible.
- R7: A write to the counter in the same cycle as an overflow wins. The counter takes the written value, and no interrupt is raised.
- R8: Offsets 5, 6 and 7 select the counter, modulo and control registers. Each stores the written byte and reads it back, with the control register keeping only bits 2:0. Other offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| op_end | input | 1 | High on the last clock of the current instruction |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
The bench walks all four rate codes and samples the counter one clock before and exactly at its first increment. A design with a prescaler off by one, or with two rate codes swapped, shows up at that edge. The deferred divider clear is checked before and after `op_end`. An eager clear would read zero too early, and a clear that left the low prefix bits behind would step the divider before 256 further clocks. Overflow is checked at the cycle the modulo value lands and for one cycle of interrupt. A software write on the overflow edge is checked separately, since a design that let the reload win, or still raised the interrupt, would fail that check.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_DIV = 4;
  localparam int unsigned OFS_CNT = 5;
  localparam int unsigned OFS_MOD = 6;
  localparam int unsigned OFS_CTL = 7;
  localparam int unsigned CTL_EN_BIT = 2;
  localparam int unsigned CTL_KEEP = 3;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_FAST = 2'b01,
    RATE_MID  = 2'b10,
    RATE_QTR  = 2'b11
  } rate_e;

  typedef struct packed {
    logic div;
    logic cnt;
    logic modr;
    logic ctl;
  } wsel_t;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PRE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req,
  input  logic              op_end,
  output logic [DATA_W-1:0] div_o
);
  localparam int unsigned TOT_W = DATA_W + PRE_BITS;

  logic [TOT_W-1:0] count_q;
  logic             pend_q;
  logic             clr_any;

  assign clr_any = clr_req || pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (clr_any && op_end) count_q <= '0;
      else                   count_q <= count_q + 1'b1;
      pend_q <= clr_any && !op_end;
    end
  end

  assign div_o = count_q[TOT_W-1:PRE_BITS];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 10,
  parameter int unsigned PER0  = 1024,
  parameter int unsigned PER1  = 16,
  parameter int unsigned PER2  = 64,
  parameter int unsigned PER3  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick_o
);
  import tmr_pkg::*;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case (rate_e'(sel))
      RATE_SLOW: lim = PRE_W'(PER0 - 1);
      RATE_FAST: lim = PRE_W'(PER1 - 1);
      RATE_MID:  lim = PRE_W'(PER2 - 1);
      default:   lim = PRE_W'(PER3 - 1);
    endcase
  end

  assign tick_o = en && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_cnt,
  input  logic              wr_mod,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] mod_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, mod_q;
  logic              irq_q;
  logic              wrap;

  assign wrap = tick && (cnt_q == {DATA_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_cnt)    cnt_q <= wdata;
      else if (wrap) cnt_q <= mod_q;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (wr_mod)    mod_q <= wdata;
      irq_q <= wrap && !wr_cnt;
    end
  end

  assign cnt_o = cnt_q;
  assign mod_o = mod_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned PRE_BITS = 8,
  parameter int unsigned PER0     = 1024,
  parameter int unsigned PER1     = 16,
  parameter int unsigned PER2     = 64,
  parameter int unsigned PER3     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              op_end,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  import tmr_pkg::*;

  localparam int unsigned PMAX01 = (PER0 > PER1) ? PER0 : PER1;
  localparam int unsigned PMAX23 = (PER2 > PER3) ? PER2 : PER3;
  localparam int unsigned PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int unsigned PRE_W  = $clog2(PMAX);

  wsel_t                 wsel;
  logic [CTL_KEEP-1:0]   ctl_q;
  logic [DATA_W-1:0]     div_q, cnt_q, mod_q;
  logic                  tick;

  always_comb begin
    wsel.div  = wr_en && (addr == ADDR_W'(OFS_DIV));
    wsel.cnt  = wr_en && (addr == ADDR_W'(OFS_CNT));
    wsel.modr = wr_en && (addr == ADDR_W'(OFS_MOD));
    wsel.ctl  = wr_en && (addr == ADDR_W'(OFS_CTL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ctl_q <= '0;
    else if (wsel.ctl) ctl_q <= wdata[CTL_KEEP-1:0];
  end

  tmr_divider #(.DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_req(wsel.div), .op_end(op_end), .div_o(div_q)
  );

  tmr_prescaler #(.PRE_W(PRE_W), .PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[CTL_EN_BIT]), .sel(ctl_q[1:0]), .tick_o(tick)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wsel.cnt), .wr_mod(wsel.modr),
    .wdata(wdata), .cnt_o(cnt_q), .mod_o(mod_q), .irq_o(irq_o)
  );

  always_comb begin
    case (addr)
      ADDR_W'(OFS_DIV): rd_data = div_q;
      ADDR_W'(OFS_CNT): rd_data = cnt_q;
      ADDR_W'(OFS_MOD): rd_data = mod_q;
      ADDR_W'(OFS_CTL): rd_data = {{(DATA_W-CTL_KEEP){1'b1}}, ctl_q};
      default:          rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              op_end,
  input logic              irq_o,
  input logic [DATA_W-1:0] div_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mod_q,
  input logic [2:0]        ctl_q
);
  import tmr_pkg::*;

  logic wr_cnt, wr_div;
  assign wr_cnt = wr_en && (addr == ADDR_W'(OFS_CNT));
  assign wr_div = wr_en && (addr == ADDR_W'(OFS_DIV));

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_q == $past(mod_q)));

  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_EN_BIT] && !wr_cnt) |=> $stable(cnt_q));

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> ((cnt_q == $past(wdata)) && !irq_o));

  p_div_now_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div && op_end) |=> (div_q == '0));

  p_div_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> ((div_q == $past(div_q) + 1'b1) || (div_q == '0)));
endmodule

bind tmr_top tmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .op_end(op_end), .irq_o(irq_o), .div_q(div_q), .cnt_q(cnt_q),
  .mod_q(mod_q), .ctl_q(ctl_q)
);

// File: tb/tmr_top_tb_top.sv
module tmr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic       op_end = 1'b0;
  logic [7:0] rd_data;
  logic       irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] V_CTL [4] = '{8'h04, 8'h05, 8'h06, 8'h07};
  localparam int         V_PER [4] = '{1024, 16, 64, 256};

  always #5 clk = ~clk;

  tmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .op_end(op_end), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(rd_data, exp, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    waitc(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(3'd4, 8'h00, "R1 div");
    rd(3'd5, 8'h00, "R1 cnt");
    rd(3'd6, 8'h00, "R1 mod");
    rd(3'd7, 8'hF8, "R1 ctl");
    chk({7'd0, irq_o}, 8'h00, "R1 irq");

    // R5 table: every rate code, sample just before and at first step
    for (int i = 0; i < 4; i++) begin
      do_reset();
      wr(3'd7, V_CTL[i]);
      waitc(V_PER[i] - 1);
      rd(3'd5, 8'h00, "R5 before step");
      waitc(1);
      rd(3'd5, 8'h01, "R5 first step");
      waitc(V_PER[i]);
      rd(3'd5, 8'h02, "R5 second step");
    end

    // R8 readback and unmapped offset
    do_reset();
    wr(3'd5, 8'hA5);
    wr(3'd6, 8'h3C);
    wr(3'd7, 8'h02);
    rd(3'd5, 8'hA5, "R8 cnt");
    rd(3'd6, 8'h3C, "R8 mod");
    rd(3'd7, 8'hFA, "R8 ctl");
    rd(3'd1, 8'h00, "R8 unmapped");

    // R4 disabled hold, then resume
    do_reset();
    wr(3'd7, 8'h01);
    waitc(100);
    rd(3'd5, 8'h00, "R4 held");
    wr(3'd7, 8'h05);
    waitc(15);
    rd(3'd5, 8'h00, "R4 not yet");
    waitc(1);
    rd(3'd5, 8'h01, "R4 resumed");

    // R6 overflow reload and pulse
    do_reset();
    wr(3'd6, 8'hF0);
    wr(3'd5, 8'hFE);
    wr(3'd7, 8'h05);
    waitc(31);
    rd(3'd5, 8'hFF, "R6 at top");
    chk({7'd0, irq_o}, 8'h00, "R6 irq before");
    waitc(1);
    rd(3'd5, 8'hF0, "R6 reloaded");
    chk({7'd0, irq_o}, 8'h01, "R6 irq high");
    waitc(1);
    chk({7'd0, irq_o}, 8'h00, "R6 irq one cycle");

    // R7 write on the overflow edge
    do_reset();
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'h33);
    wr(3'd7, 8'h05);
    waitc(15);
    wr(3'd5, 8'h77);
    rd(3'd5, 8'h77, "R7 write wins");
    chk({7'd0, irq_o}, 8'h00, "R7 no irq");
    waitc(1);
    chk({7'd0, irq_o}, 8'h00, "R7 no late irq");

    // R2 / R3 divider
    do_reset();
    waitc(600);
    rd(3'd4, 8'h02, "R2 div rate");
    wr(3'd4, 8'h9C);
    waitc(3);
    rd(3'd4, 8'h02, "R3 clear deferred");
    op_end = 1'b1;
    @(negedge clk);
    op_end = 1'b0;
    rd(3'd4, 8'h00, "R3 cleared");
    waitc(255);
    rd(3'd4, 8'h00, "R3 prefix cleared");
    waitc(1);
    rd(3'd4, 8'h01, "R2 step after clear");
    waitc(300);
    wr_en = 1'b1; addr = 3'd4; op_end = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; op_end = 1'b0;
    rd(3'd4, 8'h00, "R3 immediate clear");
    waitc(255);
    rd(3'd4, 8'h00, "R3 immediate prefix");
    waitc(1);
    rd(3'd4, 8'h01, "R3 restart");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule